// File: doc/BRIEF.md
# Hit Count Readout Sequencer

After each level-2 accept this block writes a fixed burst of seven 32-bit words into a readout buffer. The first six words carry packed per-channel summaries for 48 channels, eight channels per word, and the seventh is a header built from the event's bunch crossing, the hit-data word count, the L2 buffer slot, the chip serial bit and the module identifier. Words go out one per clock at buffer addresses 0 through 6. A one-cycle done pulse follows the header.

Every input that feeds a burst is captured in the cycle the burst starts. The upstream logic can therefore move on to the next event while the words are still being written. Accepts that arrive while a burst is running are counted and then serviced in order, each one after the burst before it has finished.

Each channel summary is a 4-bit nibble. Its top bit is set when the channel is enabled. Its low three bits hold the hit count, and any count above four is limited to four.

Top module: `hit_count_readout`

## Requirements
- R1: An accept sampled at a rising edge while the block is idle makes `buf_we_o` high for exactly seven consecutive cycles, beginning in the cycle after that edge, with `buf_addr_o` stepping 0,1,2,...,6.
- R2: Count word k (address k, k = 0..5) holds channel 8k+j in bits 4j+3..4j, so address 0 bits 3..0 carry channel 0 and address 5 bits 31..28 carry channel 47.
- R3: Bit 3 of each nibble is 1 when the channel's bit in `chan_mask_i` is 0 (enabled) and 0 when that mask bit is 1 (blocked).
- R4: Bits 2..0 of each nibble equal the channel's 3-bit count when it is 4 or less, and equal 4 when the count is 5, 6 or 7.
- R5: The word at address 6 is the header: bits 7..0 bunch crossing, bits 17..8 hit-data word count zero-extended, bits 19..18 L2 buffer number, bit 20 is 0, bit 21 chip serial bit, bit 22 is 1, bits 31..23 module ID.
- R6: `done_o` is high for exactly one cycle, the cycle immediately after the header write, and `buf_we_o` is low in that cycle; `done_o` is low at all other times.
- R7: An accept arriving during a burst is not lost: its burst starts in the cycle right after the done pulse of the running burst.
- R8: Changes on the count, mask and header inputs after a burst has started have no effect on any of that burst's seven words.
- R9: Up to 2^PEND_W-1 accepts can wait behind a running burst, and every one of them produces its own complete burst, in arrival order.
- R10: During and after reset, with no accept, `buf_we_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l2a_i | input | 1 | Level-2 accept, one pulse per event |
| hit_cnt_i | input | NUM_CH*3 | Per-channel 3-bit hit counts, channel c in bits 3c+2..3c |
| chan_mask_i | input | NUM_CH | Channel block bits, 1 = blocked |
| bx_i | input | 8 | Bunch crossing number |
| hdw_cnt_i | input | HDW_W | Number of hit-data words for the event |
| l2buf_i | input | 2 | L2 buffer slot number |
| serial_i | input | 1 | Chip serial bit |
| module_id_i | input | 9 | Module identifier |
| buf_we_o | output | 1 | Buffer write enable |
| buf_addr_o | output | 3 | Buffer word address |
| buf_wdata_o | output | 32 | Buffer write data |
| done_o | output | 1 | One-cycle pulse after the header write |

## Verification
The bench builds the block with the default 48 channels and a 7-bit hit-data count, but sets PEND_W to 2. The waiting queue then fills at three outstanding accepts, and a few pulses during one burst are enough to reach the full-queue boundary. Count patterns cover zeros, the in-range values, every count above the limit, and alternating and solid masks. The header fields are set to all-zero and to all-ones extremes, including the 96-word maximum.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

  localparam int HCR_CNT_W   = 3;
  localparam int HCR_CNT_MAX = 4;
  localparam int HCR_NIB_W   = HCR_CNT_W + 1;
  localparam int HCR_WORD_W  = 32;

  localparam int HCR_BX_W    = 8;
  localparam int HCR_HDW_W   = 10;
  localparam int HCR_L2B_W   = 2;
  localparam int HCR_MID_W   = 9;

  localparam int HDR_BX_LSB   = 0;
  localparam int HDR_HDW_LSB  = 8;
  localparam int HDR_L2B_LSB  = 18;
  localparam int HDR_ZERO_BIT = 20;
  localparam int HDR_SER_BIT  = 21;
  localparam int HDR_TYPE_BIT = 22;
  localparam int HDR_MID_LSB  = 23;

  typedef struct packed {
    logic [HCR_MID_W-1:0] mid;
    logic                 ser;
    logic [HCR_L2B_W-1:0] l2b;
    logic [HCR_HDW_W-1:0] hdw;
    logic [HCR_BX_W-1:0]  bx;
  } hdr_fields_t;

  function automatic logic [HCR_CNT_W-1:0] clamp_cnt(input logic [HCR_CNT_W-1:0] c);
    if (c > HCR_CNT_W'(HCR_CNT_MAX)) return HCR_CNT_W'(HCR_CNT_MAX);
    return c;
  endfunction

  function automatic logic [HCR_NIB_W-1:0] pack_nibble(input logic blocked,
                                                       input logic [HCR_CNT_W-1:0] c);
    return {~blocked, clamp_cnt(c)};
  endfunction

  function automatic logic [HCR_WORD_W-1:0] build_header(input hdr_fields_t f);
    logic [HCR_WORD_W-1:0] h;
    h = '0;
    h[HDR_BX_LSB  +: HCR_BX_W]  = f.bx;
    h[HDR_HDW_LSB +: HCR_HDW_W] = f.hdw;
    h[HDR_L2B_LSB +: HCR_L2B_W] = f.l2b;
    h[HDR_ZERO_BIT]             = 1'b0;
    h[HDR_SER_BIT]              = f.ser;
    h[HDR_TYPE_BIT]             = 1'b1;
    h[HDR_MID_LSB +: HCR_MID_W] = f.mid;
    return h;
  endfunction

endpackage

// File: rtl/hcr_pend_ctr.sv
module hcr_pend_ctr #(
  parameter int PEND_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic take,
  output logic has_pend
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [PEND_W-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      case ({accept, take})
        2'b10:   if (pend_q != PEND_MAX) pend_q <= pend_q + 1'b1;
        2'b01:   if (pend_q != '0)       pend_q <= pend_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign has_pend = (pend_q != '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == PEND_MAX && accept) |-> take); // R9
  AST_TAKE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (accept || pend_q != '0)); // R7

endmodule

// File: rtl/hcr_seq_ctrl.sv
module hcr_seq_ctrl #(
  parameter int LAST_IDX = 6,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  output logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] idx,
  output logic              hdr_beat,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_IDX);

  logic              busy_q;
  logic [ADDR_W-1:0] idx_q;
  logic              done_q;

  assign start    = !busy_q && req;
  assign hdr_beat = busy_q && (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= hdr_beat;
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (busy_q) begin
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;
  assign done = done_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q != LAST) |=> (busy_q && idx_q == $past(idx_q) + 1'b1)); // R1
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && idx_q == '0)); // R1
  AST_DONE_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_beat |=> (done_q && !busy_q)); // R6
  AST_DONE_ONLY_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(hdr_beat)); // R6

endmodule

// File: rtl/hcr_snapshot.sv
module hcr_snapshot
  import hcr_pkg::*;
#(
  parameter int NUM_CH = 48
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [NUM_CH*HCR_CNT_W-1:0] cnt_in,
  input  logic [NUM_CH-1:0]           mask_in,
  input  hdr_fields_t                 hdr_in,
  output logic [NUM_CH*HCR_CNT_W-1:0] cnt_q,
  output logic [NUM_CH-1:0]           mask_q,
  output hdr_fields_t                 hdr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mask_q <= '0;
      hdr_q  <= '0;
    end else if (load) begin
      cnt_q  <= cnt_in;
      mask_q <= mask_in;
      hdr_q  <= hdr_in;
    end
  end

endmodule

// File: rtl/hcr_word_mux.sv
module hcr_word_mux
  import hcr_pkg::*;
#(
  parameter int NUM_CH = 48,
  parameter int NUM_CW = 6,
  parameter int ADDR_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        sel_hdr,
  input  logic [ADDR_W-1:0]           idx,
  input  logic [NUM_CH*HCR_CNT_W-1:0] cnt,
  input  logic [NUM_CH-1:0]           mask,
  input  hdr_fields_t                 hdr,
  output logic [HCR_WORD_W-1:0]       data
);
  localparam int NIB_PER_WORD = HCR_WORD_W / HCR_NIB_W;

  logic [HCR_WORD_W-1:0] cw [NUM_CW];
  logic [HCR_WORD_W-1:0] hdr_word;

  for (genvar w = 0; w < NUM_CW; w++) begin : g_word
    for (genvar n = 0; n < NIB_PER_WORD; n++) begin : g_nib
      localparam int CH = w * NIB_PER_WORD + n;
      assign cw[w][n*HCR_NIB_W +: HCR_NIB_W] =
        pack_nibble(mask[CH], cnt[CH*HCR_CNT_W +: HCR_CNT_W]);

      AST_NIB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cw[w][n*HCR_NIB_W +: HCR_CNT_W] <= HCR_CNT_W'(HCR_CNT_MAX)); // R4
    end
  end

  assign hdr_word = build_header(hdr);

  always_comb begin
    data = '0;
    if (sel_hdr) begin
      data = hdr_word;
    end else begin
      for (int k = 0; k < NUM_CW; k++) begin
        if (idx == ADDR_W'(k)) data = cw[k];
      end
    end
  end

  AST_HDR_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sel_hdr) |-> (!data[HDR_ZERO_BIT] && data[HDR_TYPE_BIT])); // R5

endmodule

// File: rtl/hit_count_readout.sv
module hit_count_readout
  import hcr_pkg::*;
#(
  parameter int NUM_CH = 48,
  parameter int HDW_W  = 7,
  parameter int PEND_W = 3,
  localparam int NIB_PER_WORD = HCR_WORD_W / HCR_NIB_W,
  localparam int NUM_CW       = NUM_CH / NIB_PER_WORD,
  localparam int ADDR_W       = $clog2(NUM_CW + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        l2a_i,
  input  logic [NUM_CH*HCR_CNT_W-1:0] hit_cnt_i,
  input  logic [NUM_CH-1:0]           chan_mask_i,
  input  logic [HCR_BX_W-1:0]         bx_i,
  input  logic [HDW_W-1:0]            hdw_cnt_i,
  input  logic [HCR_L2B_W-1:0]        l2buf_i,
  input  logic                        serial_i,
  input  logic [HCR_MID_W-1:0]        module_id_i,
  output logic                        buf_we_o,
  output logic [ADDR_W-1:0]           buf_addr_o,
  output logic [HCR_WORD_W-1:0]       buf_wdata_o,
  output logic                        done_o
);

  logic              has_pend;
  logic              burst_start;
  logic              burst_busy;
  logic              hdr_beat;
  logic              burst_done;
  logic [ADDR_W-1:0] beat_idx;

  hdr_fields_t                 hdr_live;
  hdr_fields_t                 hdr_snap;
  logic [NUM_CH*HCR_CNT_W-1:0] cnt_snap;
  logic [NUM_CH-1:0]           mask_snap;

  assign hdr_live.bx  = bx_i;
  assign hdr_live.hdw = HCR_HDW_W'(hdw_cnt_i);
  assign hdr_live.l2b = l2buf_i;
  assign hdr_live.ser = serial_i;
  assign hdr_live.mid = module_id_i;

  hcr_pend_ctr #(.PEND_W(PEND_W)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (l2a_i),
    .take     (burst_start),
    .has_pend (has_pend)
  );

  hcr_seq_ctrl #(.LAST_IDX(NUM_CW), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (l2a_i || has_pend),
    .start    (burst_start),
    .busy     (burst_busy),
    .idx      (beat_idx),
    .hdr_beat (hdr_beat),
    .done     (burst_done)
  );

  hcr_snapshot #(.NUM_CH(NUM_CH)) u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (burst_start),
    .cnt_in  (hit_cnt_i),
    .mask_in (chan_mask_i),
    .hdr_in  (hdr_live),
    .cnt_q   (cnt_snap),
    .mask_q  (mask_snap),
    .hdr_q   (hdr_snap)
  );

  hcr_word_mux #(.NUM_CH(NUM_CH), .NUM_CW(NUM_CW), .ADDR_W(ADDR_W)) u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (burst_busy),
    .sel_hdr (hdr_beat),
    .idx     (beat_idx),
    .cnt     (cnt_snap),
    .mask    (mask_snap),
    .hdr     (hdr_snap),
    .data    (buf_wdata_o)
  );

  assign buf_we_o   = burst_busy;
  assign buf_addr_o = beat_idx;
  assign done_o     = burst_done;

  AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_busy |=> $stable({cnt_snap, mask_snap, hdr_snap})); // R8
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_busy && !burst_start) |=> !buf_we_o); // R10

endmodule

// File: tb/hit_count_readout_tb.sv
module hit_count_readout_tb;

  localparam int NCH = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          l2a = 1'b0;
  logic [NCH*3-1:0] t_cnt = '0;
  logic [NCH-1:0]   t_mask = '0;
  logic [7:0]    t_bx = '0;
  logic [6:0]    t_hdw = '0;
  logic [1:0]    t_l2b = '0;
  logic          t_ser = 1'b0;
  logic [8:0]    t_mid = '0;
  logic          we;
  logic [2:0]    addr;
  logic [31:0]   wdata;
  logic          done;

  always #5 clk = ~clk;

  hit_count_readout #(.NUM_CH(NCH), .HDW_W(7), .PEND_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .l2a_i(l2a), .hit_cnt_i(t_cnt), .chan_mask_i(t_mask),
    .bx_i(t_bx), .hdw_cnt_i(t_hdw), .l2buf_i(t_l2b), .serial_i(t_ser),
    .module_id_i(t_mid), .buf_we_o(we), .buf_addr_o(addr), .buf_wdata_o(wdata),
    .done_o(done)
  );

  typedef struct {
    logic [2:0]  a;
    logic [31:0] d;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   hdr_seen = 1'b0;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Reference packing, written from the requirements
  function automatic logic [31:0] model_word(input int k);
    logic [31:0] w;
    w = '0;
    if (k < 6) begin
      for (int n = 0; n < 8; n++) begin
        int ch;
        logic [2:0] c;
        ch = k * 8 + n;
        c  = t_cnt[ch*3 +: 3];
        if (c > 3'd4) c = 3'd4;
        w[n*4 +: 4] = {!t_mask[ch], c};
      end
    end else begin
      w = {t_mid, 1'b1, t_ser, 1'b0, t_l2b, 3'b000, t_hdw, t_bx};
    end
    return w;
  endfunction

  task automatic push_burst(input string tag);
    for (int k = 0; k < 7; k++) begin
      exp_t e;
      e.a = 3'(k);
      e.d = model_word(k);
      e.tag = (k < 6) ? tag : "R5";
      exp_q.push_back(e);
    end
  endtask

  // Driver: one accept pulse, expected words queued from current inputs
  task automatic issue(input string tag, input bit expect_now);
    @(negedge clk);
    l2a = 1'b1;
    push_burst(tag);
    @(negedge clk);
    l2a = 1'b0;
    if (expect_now)
      chk(we === 1'b1 && addr === 3'd0, "R1 first write", {28'b0, we, addr}, 32'h8);
  endtask

  task automatic drain(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops and compares
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (hdr_seen) begin
        chk(done === 1'b1 && we === 1'b0, "R6 done after header", {30'b0, done, we}, 32'h2);
        hdr_seen = 1'b0;
      end else if (done === 1'b1) begin
        chk(1'b0, "R6 stray done", 32'h1, 32'h0);
      end
      if (we === 1'b1) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected write", {29'b0, addr}, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(addr === e.a, "R1 address", {29'b0, addr}, {29'b0, e.a});
          chk(wdata === e.d, e.tag, wdata, e.d);
          if (e.a == 3'd6) hdr_seen = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(we === 1'b0 && done === 1'b0, "R10 in reset", {30'b0, we, done}, 32'h0);
    rst_n = 1'b1;
    drain(3);
    chk(we === 1'b0 && done === 1'b0, "R10 idle after reset", {30'b0, we, done}, 32'h0);

    // all zero counts, all enabled, header minimum
    issue("R2 R3 zero counts", 1'b1);
    drain(10);

    // counts 0..7 cycling, including values above the limit
    for (int c = 0; c < NCH; c++) t_cnt[c*3 +: 3] = 3'(c % 8);
    t_mask = {24{2'b10}};
    t_bx = 8'hFF; t_hdw = 7'd96; t_l2b = 2'd3; t_ser = 1'b1; t_mid = 9'h1FF;
    issue("R4 clamp pattern", 1'b1);
    drain(10);

    // all counts at 7, all blocked
    t_cnt = '1; t_mask = '1;
    t_bx = 8'h5A; t_hdw = 7'd1; t_l2b = 2'd1; t_ser = 1'b0; t_mid = 9'h0A5;
    issue("R3 R4 blocked saturated", 1'b1);
    drain(10);

    // R8: inputs change right after burst start
    for (int c = 0; c < NCH; c++) t_cnt[c*3 +: 3] = 3'((c * 5 + 1) % 5);
    t_mask = 48'h0000_FFFF_0F0F;
    t_bx = 8'h12; t_hdw = 7'd40; t_l2b = 2'd2; t_ser = 1'b1; t_mid = 9'h123;
    issue("R8 held inputs", 1'b1);
    t_cnt = '1; t_mask = '1; t_bx = 8'h00; t_hdw = 7'd0; t_l2b = 2'd0;
    t_ser = 1'b0; t_mid = 9'h000;
    drain(10);

    // R7: accept during a burst, new inputs for the second one
    t_cnt = '0; t_mask = 48'h8000_0000_0001;
    for (int c = 0; c < NCH; c++) if (c % 3 == 0) t_cnt[c*3 +: 3] = 3'd2;
    t_bx = 8'h33;
    issue("R7 first", 1'b1);
    drain(2);
    t_bx = 8'h44; t_mid = 9'h0F0; t_cnt = {16{3'd4, 3'd3, 3'd1}};
    issue("R7 queued", 1'b0);
    while (done !== 1'b1) @(negedge clk);
    @(negedge clk);
    chk(we === 1'b1 && addr === 3'd0, "R7 queued start after done", {28'b0, we, addr}, 32'h8);
    drain(12);

    // R9: fill the waiting queue to its limit of three
    t_bx = 8'h77; t_l2b = 2'd1;
    issue("R9 burst a", 1'b1);
    issue("R9 burst b", 1'b0);
    issue("R9 burst c", 1'b0);
    issue("R9 burst d", 1'b0);
    drain(40);
    chk(exp_q.size() == 0, "R9 all bursts serviced", 32'(exp_q.size()), 32'h0);
    chk(we === 1'b0 && done === 1'b0, "R10 idle at end", {30'b0, we, done}, 32'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule